// File: doc/BRIEF.md
# Serial-Access General Purpose Register Pair

This block holds two 12-bit scratch registers that a host controller reads and writes over a four-wire serial link. The host pulls chip select low and shifts in a 16-bit frame, MSB first. The first two bits choose the register and the next bit chooses which word comes back. The following bit marks the frame as read-only. The last twelve bits are write data. While the frame is still running, the block shifts back the word that was selected. It is either the register's own contents or an alternate status word that comes in on an input port. A write takes effect only when chip select rises after exactly sixteen clocks.

Register 0 starts with a device identification code, built from a type field and a version field. Its top bit is a flag that reads 0 while that code is still in place. Any write to register 0 sets the flag to 1, whatever bit 11 of the frame holds, so the host can tell whether the code has been replaced. The serial inputs are sampled by the block's own clock, which must run well above the serial clock rate.

Top module: `gpr_serial_pair`

## Requirements
- R1: After reset, register 0 reads back as {flag=0, ID}, where the 11-bit ID is {DEV_TYPE, DEV_VER}. Register 1 reads back as GP1_INIT (default 0).
- R2: Frame bits 15:14 carry the address: code 2'b10 selects register 0 and code 2'b11 selects register 1. In slots 0 to 3 (counted from the MSB) `miso_oe_o` is low. In slots 4 to 15 it is high, and `miso_o` carries the selected 12-bit word, MSB first. Each bit is launched on the falling serial clock edge before its slot.
- R3: When frame bit 13 is 1, the returned word is the addressed register. When it is 0, the returned word is `alt_cfg_i` for address 2'b10 and `alt_phy_i` for address 2'b11.
- R4: When frame bit 12 is 1, neither register changes.
- R5: When frame bit 12 is 0, a 16-bit frame to address 2'b11 loads frame bits 11:0 into register 1 as chip select rises. The word returned during that frame is the value held before the write.
- R6: A write to register 0 stores frame bits 10:0 and sets the flag (register bit 11) to 1, whatever frame bit 11 holds. The flag is never cleared except by reset.
- R7: A frame that ends after any number of serial clocks other than 16 (for example 0, 15 or 17) writes nothing.
- R8: Frames with address 2'b00 or 2'b01 write nothing and keep `miso_oe_o` and `miso_o` low for the whole frame.
- R9: Asserting `rst_ni` at any time restores the identification code and clears the flag.
- R10: `miso_o` is 0 whenever `miso_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; all serial inputs are sampled on it |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock, idles low |
| csn_i | input | 1 | Active-low chip select |
| mosi_i | input | 1 | Serial data from the host |
| alt_cfg_i | input | 12 | Alternate readback word for address 2'b10 |
| alt_phy_i | input | 12 | Alternate readback word for address 2'b11 |
| miso_o | output | 1 | Serial data to the host |
| miso_oe_o | output | 1 | High while this block drives `miso_o` |

## Verification
A bad bit counter shows in the very next frame. Either the data enable comes on in the wrong slot, or a frame of 15 or 17 bits changes a register, and the following read exposes that. A wrong register value or a flag that is not set stays hidden until the next read of that register. For that reason every write and every rejected frame is followed by a read within one frame. The alternate words are changed between frames, so a stuck read multiplexer shows up in the same frame where it goes wrong.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int unsigned GPR_DATA_W = 12;
  localparam int unsigned GPR_ADDR_W = 2;
  localparam int unsigned GPR_HDR_W  = GPR_ADDR_W + 2;

  typedef enum logic [GPR_ADDR_W-1:0] {
    ADR_GP0 = 2'b10,
    ADR_GP1 = 2'b11
  } gpr_addr_e;
endpackage

// File: rtl/gpr_shift_rx.sv
module gpr_shift_rx #(
  parameter int unsigned FRAME_W = 16,
  parameter int unsigned CNT_W   = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sck_i,
  input  logic               csn_i,
  input  logic               mosi_i,
  output logic               sck_fall_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic               done_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_W + 1);

  logic sck_q, csn_q, sck_rise;

  assign sck_rise   = sck_i & ~sck_q & ~csn_i;
  assign sck_fall_o = ~sck_i & sck_q & ~csn_i;
  assign done_o     = csn_i & ~csn_q & (cnt_o == CNT_FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q   <= 1'b0;
      csn_q   <= 1'b1;
      cnt_o   <= '0;
      frame_o <= '0;
    end else begin
      sck_q <= sck_i;
      csn_q <= csn_i;
      if (csn_i) begin
        cnt_o <= '0;
      end else if (sck_rise) begin
        frame_o <= {frame_o[FRAME_W-2:0], mosi_i};
        // saturate one past full so long frames stay invalid
        if (cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/gpr_regfile.sv
module gpr_regfile #(
  parameter int unsigned DATA_W              = 12,
  parameter int unsigned TYPE_W              = 7,
  parameter int unsigned VER_W               = 4,
  parameter logic [TYPE_W-1:0] DEV_TYPE      = 7'h2C,
  parameter logic [VER_W-1:0]  DEV_VER       = 4'h3,
  parameter logic [DATA_W-1:0] GP1_INIT      = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              sel1_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] gp0_o,
  output logic [DATA_W-1:0] gp1_o
);
  localparam int unsigned ID_W = DATA_W - 1;
  localparam logic [ID_W-1:0] ID_CODE = {DEV_TYPE, DEV_VER};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gp0_o <= {1'b0, ID_CODE};
      gp1_o <= GP1_INIT;
    end else if (wr_i) begin
      if (sel1_i) gp1_o <= wdata_i;
      else        gp0_o <= {1'b1, wdata_i[ID_W-1:0]};  // flag set on any write
    end
  end
endmodule

// File: rtl/gpr_readout.sv
module gpr_readout #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned HDR_W  = 4,
  parameter int unsigned CNT_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csn_i,
  input  logic              sck_fall_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [HDR_W-1:0]  hdr_i,
  input  logic [DATA_W-1:0] gp0_i,
  input  logic [DATA_W-1:0] gp1_i,
  input  logic [DATA_W-1:0] alt_cfg_i,
  input  logic [DATA_W-1:0] alt_phy_i,
  output logic              miso_o,
  output logic              oe_o
);
  localparam int unsigned FRAME_W = HDR_W + DATA_W;
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);

  logic              hit, sel1, own;
  logic [DATA_W-1:0] word, tx_q;

  // header: {a1, a0, read-select, read-only}
  assign hit  = hdr_i[HDR_W-1];
  assign sel1 = hdr_i[HDR_W-2];
  assign own  = hdr_i[1];

  always_comb begin
    if (sel1) word = own ? gp1_i : alt_phy_i;
    else      word = own ? gp0_i : alt_cfg_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_o <= 1'b0;
      tx_q <= '0;
    end else if (csn_i) begin
      oe_o <= 1'b0;
      tx_q <= '0;
    end else if (sck_fall_i) begin
      if (cnt_i == CNT_HDR && hit) begin
        oe_o <= 1'b1;
        tx_q <= word;
      end else if (oe_o && cnt_i > CNT_HDR && cnt_i <= CNT_LAST) begin
        tx_q <= {tx_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign miso_o = oe_o & tx_q[DATA_W-1];
endmodule

// File: rtl/gpr_serial_pair.sv
module gpr_serial_pair
  import gpr_pkg::*;
#(
  parameter int unsigned DATA_W         = GPR_DATA_W,
  parameter int unsigned TYPE_W         = 7,
  parameter int unsigned VER_W          = 4,
  parameter logic [TYPE_W-1:0] DEV_TYPE = 7'h2C,
  parameter logic [VER_W-1:0]  DEV_VER  = 4'h3,
  parameter logic [DATA_W-1:0] GP1_INIT = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              csn_i,
  input  logic              mosi_i,
  input  logic [DATA_W-1:0] alt_cfg_i,
  input  logic [DATA_W-1:0] alt_phy_i,
  output logic              miso_o,
  output logic              miso_oe_o
);
  localparam int unsigned HDR_W   = GPR_HDR_W;
  localparam int unsigned FRAME_W = HDR_W + DATA_W;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 2);

  logic               sck_fall, frame_done, wr_en;
  logic [CNT_W-1:0]   rx_cnt;
  logic [FRAME_W-1:0] rx_frame;
  logic [DATA_W-1:0]  gp0_q, gp1_q;
  gpr_addr_e          frame_addr;

  gpr_shift_rx #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_rx (
    .clk_i, .rst_ni, .sck_i, .csn_i, .mosi_i,
    .sck_fall_o (sck_fall),
    .cnt_o      (rx_cnt),
    .frame_o    (rx_frame),
    .done_o     (frame_done)
  );

  assign frame_addr = gpr_addr_e'(rx_frame[FRAME_W-1 -: GPR_ADDR_W]);
  // write only on a complete, addressed, writable frame
  assign wr_en = frame_done && rx_frame[FRAME_W-1] && !rx_frame[DATA_W];

  gpr_regfile #(
    .DATA_W(DATA_W), .TYPE_W(TYPE_W), .VER_W(VER_W),
    .DEV_TYPE(DEV_TYPE), .DEV_VER(DEV_VER), .GP1_INIT(GP1_INIT)
  ) u_regs (
    .clk_i, .rst_ni,
    .wr_i    (wr_en),
    .sel1_i  (frame_addr == ADR_GP1),
    .wdata_i (rx_frame[DATA_W-1:0]),
    .gp0_o   (gp0_q),
    .gp1_o   (gp1_q)
  );

  gpr_readout #(.DATA_W(DATA_W), .HDR_W(HDR_W), .CNT_W(CNT_W)) u_out (
    .clk_i, .rst_ni, .csn_i,
    .sck_fall_i (sck_fall),
    .cnt_i      (rx_cnt),
    .hdr_i      (rx_frame[HDR_W-1:0]),
    .gp0_i      (gp0_q),
    .gp1_i      (gp1_q),
    .alt_cfg_i, .alt_phy_i,
    .miso_o,
    .oe_o       (miso_oe_o)
  );
endmodule

// File: rtl/gpr_serial_pair_chk.sv
module gpr_serial_pair_chk #(
  parameter int unsigned DATA_W  = 12,
  parameter int unsigned HDR_W   = 4,
  parameter int unsigned CNT_W   = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              csn_i,
  input logic              miso_o,
  input logic              miso_oe_o,
  input logic [CNT_W-1:0]  cnt,
  input logic [DATA_W-1:0] gp0,
  input logic [DATA_W-1:0] gp1
);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_W);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(HDR_W + DATA_W);

  // R10
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !miso_oe_o |-> !miso_o);

  // R2
  oe_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(miso_oe_o) |-> (cnt == CNT_HDR) && !csn_i);

  // R7
  full_frame_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(gp0) || !$stable(gp1)) |-> ($past(cnt) == CNT_FULL));

  // R5
  wr_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(gp1) |-> $past(csn_i));

  // R6
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(gp0[DATA_W-1]));

  // R6
  flag_on_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(gp0) |-> gp0[DATA_W-1]);
endmodule

bind gpr_serial_pair gpr_serial_pair_chk #(
  .DATA_W(DATA_W), .HDR_W(HDR_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i, .rst_ni, .csn_i, .miso_o, .miso_oe_o,
  .cnt (rx_cnt),
  .gp0 (gp0_q),
  .gp1 (gp1_q)
);

// File: tb/gpr_serial_pair_test.sv
module gpr_serial_pair_test;
  localparam logic [10:0] EXP_ID = {7'h2C, 4'h3};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sck = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic [11:0] alt_cfg = 12'h000, alt_phy = 12'h000;
  logic miso, oe;
  logic [11:0] m0, m1, rw;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpr_serial_pair uut (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck), .csn_i(csn), .mosi_i(mosi),
    .alt_cfg_i(alt_cfg), .alt_phy_i(alt_phy), .miso_o(miso), .miso_oe_o(oe)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    m0 = {1'b0, EXP_ID};
    m1 = 12'h000;
    repeat (2) @(negedge clk);
  endtask

  task automatic xfer(input logic [1:0] a, input logic rrs, input logic ro,
                      input logic [11:0] d, input int nbits, input string tag,
                      output logic [11:0] word);
    logic [15:0] f;
    logic [11:0] ew;
    logic [19:0] g_oe, g_mi, e_oe, e_mi;
    f = {a, rrs, ro, d};
    ew = (a == 2'b10) ? (rrs ? m0 : alt_cfg) : (rrs ? m1 : alt_phy);
    g_oe = '0; g_mi = '0; e_oe = '0; e_mi = '0; word = '0;
    @(negedge clk) csn = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      int idx;
      idx = (i >= 15) ? 0 : 15 - i;
      mosi = (i < 16) ? f[15-i] : 1'b0;
      repeat (3) @(negedge clk);
      g_oe[i] = oe;
      g_mi[i] = miso;
      e_oe[i] = a[1] && (i >= 4);
      e_mi[i] = e_oe[i] ? ew[idx] : 1'b0;
      if (i >= 4 && i < 16) word[15-i] = miso;
      sck = 1'b1;
      repeat (3) @(negedge clk);
      sck = 1'b0;
      repeat (3) @(negedge clk);
    end
    csn = 1'b1;
    repeat (4) @(negedge clk);
    chk(g_oe == e_oe, tag, "drive enable per slot", 32'(g_oe), 32'(e_oe));
    chk(g_mi == e_mi, tag, "serial data per slot", 32'(g_mi), 32'(e_mi));
    if (nbits == 16 && a[1] && !ro) begin
      if (a[0]) m1 = d;
      else      m0 = {1'b1, d[10:0]};
    end
  endtask

  task automatic rd(input logic [1:0] a, input string tag, input logic [11:0] exp);
    xfer(a, 1'b1, 1'b1, 12'hFFF, 16, tag, rw);
    chk(rw == exp, tag, "register readback", 32'(rw), 32'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m0 = {1'b0, EXP_ID};
    m1 = 12'h000;
    repeat (2) @(negedge clk);
    chk(oe == 1'b0 && miso == 1'b0, "R10", "outputs in reset", {30'd0, oe, miso}, 32'd0);
    do_reset();

    // R1 reset contents
    rd(2'b10, "R1", {1'b0, EXP_ID});
    rd(2'b11, "R1", 12'h000);

    // R3 alternate words
    alt_cfg = 12'hA5A; alt_phy = 12'h3C3;
    xfer(2'b10, 1'b0, 1'b1, 12'h000, 16, "R3", rw);
    chk(rw == 12'hA5A, "R3", "config alternate", 32'(rw), 32'hA5A);
    xfer(2'b11, 1'b0, 1'b1, 12'h000, 16, "R3", rw);
    chk(rw == 12'h3C3, "R3", "phy alternate", 32'(rw), 32'h3C3);

    // R5 write reg1, read-before-write
    xfer(2'b11, 1'b1, 1'b0, 12'h9E1, 16, "R5", rw);
    chk(rw == 12'h000, "R5", "old value during write", 32'(rw), 32'h000);
    rd(2'b11, "R5", 12'h9E1);

    // R6 flag set regardless of bit 11
    xfer(2'b10, 1'b0, 1'b0, 12'h123, 16, "R6", rw);
    rd(2'b10, "R6", 12'h923);
    xfer(2'b10, 1'b1, 1'b0, 12'h855, 16, "R6", rw);
    rd(2'b10, "R6", 12'h855);

    // R4 read-only leaves both
    xfer(2'b10, 1'b1, 1'b1, 12'h0F0, 16, "R4", rw);
    xfer(2'b11, 1'b0, 1'b1, 12'h0F0, 16, "R4", rw);
    rd(2'b10, "R4", 12'h855);
    rd(2'b11, "R4", 12'h9E1);

    // R7 wrong lengths
    xfer(2'b11, 1'b1, 1'b0, 12'h444, 15, "R7", rw);
    xfer(2'b11, 1'b1, 1'b0, 12'h444, 17, "R7", rw);
    xfer(2'b10, 1'b1, 1'b0, 12'h444, 0, "R7", rw);
    rd(2'b11, "R7", 12'h9E1);
    rd(2'b10, "R7", 12'h855);

    // R8 unowned addresses
    xfer(2'b00, 1'b1, 1'b0, 12'h777, 16, "R8", rw);
    xfer(2'b01, 1'b1, 1'b0, 12'h777, 16, "R8", rw);
    rd(2'b10, "R8", 12'h855);
    rd(2'b11, "R8", 12'h9E1);

    // R2 sweep over address, read-select, read-only and data
    for (int a = 0; a < 4; a++)
      for (int s = 0; s < 2; s++)
        for (int r = 0; r < 2; r++)
          for (int k = 0; k < 4; k++) begin
            logic [11:0] d;
            d = 12'((k * 12'h2A7 + a * 12'h111) & 12'hFFF);
            alt_cfg = d ^ 12'h5A5;
            alt_phy = ~d;
            xfer(2'(a), s[0], r[0], d, 16, "R2", rw);
          end
    rd(2'b10, "R2", m0);
    rd(2'b11, "R2", m1);

    // R9 reset mid-run
    xfer(2'b11, 1'b1, 1'b0, 12'hBEE, 16, "R9", rw);
    do_reset();
    rd(2'b10, "R9", {1'b0, EXP_ID});
    rd(2'b11, "R9", 12'h000);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule